// File: doc/BRIEF.md
# Sample Gain and Offset Corrector

This block sits directly on the 16-bit output of a data converter and corrects every sample before any other logic sees it. Each accepted raw sample (an unsigned code, 0x0000 at zero volts, 0xFFFF at full scale) first has a signed calibration offset subtracted. The difference is then multiplied by an unsigned fixed-point gain with 14 fractional bits, rounded to the nearest integer and clamped to the 16-bit code range. The final code is presented either as an unsigned value or in an offset-coded two's-complement form, where the most significant bit is inverted.

Software loads the offset, gain and format once through a single-cycle write strobe. From then on every sample is corrected with no further action. A write takes effect at a sample boundary: the factors that were in force when a sample was accepted travel down the pipeline with that sample. The pipeline accepts one sample per clock and presents the result two clocks after the input strobe.

Top module: `gain_offset_corrector`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0x0000. The factors reset to offset 0, gain 0x4000 and unsigned format, so a raw sample passes through unchanged.
- R2: A sample accepted with `in_valid` high at clock edge k gives `out_valid` high for exactly one cycle after edge k+1. Samples may arrive on consecutive cycles. `out_data` holds its value while `out_valid` is low.
- R3: The offset is a signed 16-bit value subtracted from the raw unsigned code before the gain is applied. At unity gain the result is raw minus offset.
- R4: The gain is unsigned with 14 fractional bits (0x4000 = 1.0). The result is floor((diff*gain + 8192) / 16384), so an exact half rounds up.
- R5: A result below zero is clamped to the minimum code of the selected format: 0x0000 unsigned, 0x8000 two's complement.
- R6: A result above 65535 is clamped to the maximum code of the selected format: 0xFFFF unsigned, 0x7FFF two's complement.
- R7: With `cfg_fmt` = 0 (unsigned), the output is the corrected code itself. Zero volts gives 0x0000 and full scale gives 0xFFFF.
- R8: With `cfg_fmt` = 1 (two's complement), the output is the corrected code with bit 15 inverted. Zero volts gives 0x8000 and full scale gives 0x7FFF.
- R9: A sample accepted in the same cycle as `cfg_wr` is corrected entirely with the previous factors. Every later sample uses entirely the new ones.
- R10: Loaded factors stay in force for all later samples until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Raw sample strobe |
| in_data | input | 16 | Raw unsigned converter code |
| cfg_wr | input | 1 | Factor load strobe |
| cfg_offset | input | 16 | Signed offset to subtract |
| cfg_gain | input | 16 | Unsigned gain, 14 fractional bits |
| cfg_fmt | input | 1 | Output coding: 0 unsigned, 1 two's complement |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 16 | Corrected, formatted code |

## Verification
The hardest case to create from the ports is a factor write that lands in the same cycle as an accepted sample while other samples are already in flight. Only that case can show a sample corrected with a mix of old and new factors. The stimulus forces this case directly, with back-to-back samples around a gain change. It then runs a long seeded random phase in which writes, format changes and sample gaps are interleaved freely. Gains up to four times unity and offsets near both signed limits drive results into both clamps in both formats.

// File: rtl/gocf_pkg.sv
package gocf_pkg;
    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_TWOS     = 1'b1
    } fmt_e;
endpackage

// File: rtl/gocf_offset_stage.sv
module gocf_offset_stage
    import gocf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int GAIN_W = 16,
    localparam int DIFF_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W-1:0]        fac_offset,
    input  logic [GAIN_W-1:0]        fac_gain,
    input  fmt_e                     fac_fmt,
    output logic                     s1_valid,
    output logic signed [DIFF_W-1:0] s1_diff,
    output logic [GAIN_W-1:0]        s1_gain,
    output fmt_e                     s1_fmt
);
    typedef struct packed {
        logic                     valid;
        logic signed [DIFF_W-1:0] diff;
        logic [GAIN_W-1:0]        gain;
        fmt_e                     fmt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            // raw code is zero-extended, offset is sign-extended
            st_d.diff = $signed({2'b00, in_data})
                      - $signed({{2{fac_offset[DATA_W-1]}}, fac_offset});
            st_d.gain = fac_gain;
            st_d.fmt  = fac_fmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, diff: '0, gain: '0, fmt: FMT_UNSIGNED};
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_diff  = st_q.diff;
    assign s1_gain  = st_q.gain;
    assign s1_fmt   = st_q.fmt;

    // R2: every accepted sample reaches the multiply stage next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
endmodule

// File: rtl/gocf_format.sv
module gocf_format
    import gocf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] code_i,
    input  fmt_e              fmt_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = code_i;
        if (fmt_i == FMT_TWOS) begin
            data_o[DATA_W-1] = ~code_i[DATA_W-1];
        end
    end
endmodule

// File: rtl/gocf_gain_stage.sv
module gocf_gain_stage
    import gocf_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    localparam int DIFF_W   = DATA_W + 2,
    localparam int PROD_W   = DIFF_W + GAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic signed [DIFF_W-1:0] s1_diff,
    input  logic [GAIN_W-1:0]        s1_gain,
    input  fmt_e                     s1_fmt,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data
);
    localparam logic signed [PROD_W-1:0] HALF_LSB  = PROD_W'(64'sd1 <<< (GAIN_FRAC - 1));
    localparam logic signed [PROD_W-1:0] CODE_MAX  = PROD_W'((64'sd1 <<< DATA_W) - 64'sd1);
    localparam logic signed [DIFF_W-1:0] DIFF_FULL = DIFF_W'((64'sd1 <<< DATA_W) - 64'sd1);
    localparam logic [GAIN_W-1:0]        UNITY     = GAIN_W'(1) << GAIN_FRAC;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic signed [PROD_W-1:0] prod, rounded, scaled;
    logic [DATA_W-1:0]        code_sat, code_fmt;

    always_comb begin
        prod    = PROD_W'(s1_diff) * PROD_W'($signed({1'b0, s1_gain}));
        rounded = prod + HALF_LSB;
        scaled  = rounded >>> GAIN_FRAC;
        if (scaled[PROD_W-1]) begin
            code_sat = '0;
        end else if (scaled > CODE_MAX) begin
            code_sat = '1;
        end else begin
            code_sat = scaled[DATA_W-1:0];
        end
    end

    gocf_format #(.DATA_W(DATA_W)) i_format (
        .code_i (code_sat),
        .fmt_i  (s1_fmt),
        .data_o (code_fmt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = s1_valid;
        if (s1_valid) begin
            st_d.data = code_fmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

    // R2: one output strobe per staged sample, none otherwise
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> (!out_valid && $stable(out_data)));
    // R5: negative difference clamps to the format minimum
    p_low_uns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_diff[DIFF_W-1] && s1_fmt == FMT_UNSIGNED) |=> out_data == '0);
    p_low_twos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_diff[DIFF_W-1] && s1_fmt == FMT_TWOS)
        |=> out_data == {1'b1, {(DATA_W-1){1'b0}}});
    // R6: full-scale difference with gain at or above unity hits the maximum
    p_high_uns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_diff[DIFF_W-1] && s1_diff >= DIFF_FULL && s1_gain >= UNITY
         && s1_fmt == FMT_UNSIGNED) |=> out_data == '1);
    // R3: unity gain passes an in-range difference unchanged
    p_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_gain == UNITY && !s1_diff[DIFF_W-1] && s1_diff <= DIFF_FULL
         && s1_fmt == FMT_UNSIGNED) |=> out_data == $past(s1_diff[DATA_W-1:0]));
endmodule

// File: rtl/gain_offset_corrector.sv
module gain_offset_corrector
    import gocf_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_offset,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              cfg_fmt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int          DIFF_W     = DATA_W + 2;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << GAIN_FRAC;

    typedef struct packed {
        logic [DATA_W-1:0] offset;
        logic [GAIN_W-1:0] gain;
        fmt_e              fmt;
    } fac_t;

    fac_t fac_d, fac_q;

    always_comb begin
        fac_d = fac_q;
        if (cfg_wr) begin
            fac_d.offset = cfg_offset;
            fac_d.gain   = cfg_gain;
            fac_d.fmt    = fmt_e'(cfg_fmt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fac_q <= '{offset: '0, gain: GAIN_UNITY, fmt: FMT_UNSIGNED};
        end else begin
            fac_q <= fac_d;
        end
    end

    logic                     s1_valid;
    logic signed [DIFF_W-1:0] s1_diff;
    logic [GAIN_W-1:0]        s1_gain;
    fmt_e                     s1_fmt;

    gocf_offset_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_offset (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .fac_offset (fac_q.offset),
        .fac_gain   (fac_q.gain),
        .fac_fmt    (fac_q.fmt),
        .s1_valid   (s1_valid),
        .s1_diff    (s1_diff),
        .s1_gain    (s1_gain),
        .s1_fmt     (s1_fmt)
    );

    gocf_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) i_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_diff   (s1_diff),
        .s1_gain   (s1_gain),
        .s1_fmt    (s1_fmt),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R9: a sample staged in a write cycle carries the factors in force before the write
    p_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_wr) |=> s1_gain == $past(fac_q.gain) && s1_fmt == $past(fac_q.fmt));
endmodule

// File: tb/test_gain_offset_corrector.sv
module test_gain_offset_corrector;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_offset = '0;
    logic [15:0] cfg_gain = 16'h4000;
    logic        cfg_fmt = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gain_offset_corrector i_gain_offset_corrector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_wr(cfg_wr), .cfg_offset(cfg_offset), .cfg_gain(cfg_gain), .cfg_fmt(cfg_fmt),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] model(logic [15:0] raw, logic [15:0] off,
                                          logic [15:0] g, bit f);
        longint dd = longint'(raw) - longint'($signed(off));
        longint r  = (dd * longint'(g) + 64'sd8192) >>> 14;
        if (r < 0) r = 0;
        if (r > 65535) r = 65535;
        return 16'(r) ^ (f ? 16'h8000 : 16'h0000);
    endfunction

    // bench-side factor shadow and two-deep expectation pipeline
    logic [15:0] m_off, m_gain;
    bit          m_fmt;
    bit          e1_v, e2_v;
    logic [15:0] e1_d, e2_d;
    string       e1_t, e2_t, cur_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_off <= '0; m_gain <= 16'h4000; m_fmt <= 1'b0;
            e1_v <= 1'b0; e2_v <= 1'b0;
        end else begin
            e2_v <= e1_v; e2_d <= e1_d; e2_t <= e1_t;
            e1_v <= in_valid;
            e1_t <= cur_tag;
            if (in_valid) e1_d <= model(in_data, m_off, m_gain, m_fmt);
            if (cfg_wr) begin
                m_off <= cfg_offset; m_gain <= cfg_gain; m_fmt <= cfg_fmt;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (out_valid !== e2_v) begin
                n_fails++;
                $display("FAIL R2 out_valid got %b exp %b", out_valid, e2_v);
            end else if (e2_v) begin
                n_checks++;
                if (out_data !== e2_d) begin
                    n_fails++;
                    $display("FAIL %s out_data got %h exp %h", e2_t, out_data, e2_d);
                end
            end
        end
    end

    task automatic drive(bit v, logic [15:0] d, bit w, logic [15:0] o,
                         logic [15:0] g, bit f, string t);
        in_valid = v; in_data = d; cfg_wr = w;
        if (w) begin cfg_offset = o; cfg_gain = g; cfg_fmt = f; end
        cur_tag = t;
        @(negedge clk);
        in_valid = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic load(logic [15:0] o, logic [15:0] g, bit f, string t);
        drive(1'b0, 16'h0, 1'b1, o, g, f, t);
    endtask

    task automatic sample(logic [15:0] d, string t);
        drive(1'b1, d, 1'b0, 16'h0, 16'h0, 1'b0, t);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is still applied
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== 16'h0000) begin
            n_fails++;
            $display("FAIL R1 reset outputs got %b/%h exp 0/0000", out_valid, out_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        sample(16'd1234, "R1");
        sample(16'hFFFF, "R1");
        idle(3);

        load(16'd100, 16'h4000, 1'b0, "R3");
        sample(16'd1000, "R3");
        load(16'hFF9C, 16'h4000, 1'b0, "R3");      // offset -100
        sample(16'd1000, "R3");
        load(16'd0, 16'h6000, 1'b0, "R4");         // gain 1.5
        sample(16'd3, "R4");                       // 4.5 rounds to 5
        load(16'd0, 16'h2000, 1'b0, "R4");         // gain 0.5
        sample(16'd1, "R4");
        sample(16'd3, "R4");
        load(16'd0, 16'h5555, 1'b0, "R4");
        sample(16'd12345, "R4");
        load(16'd2000, 16'h4000, 1'b0, "R5");
        sample(16'd100, "R5");
        load(16'd2000, 16'h4000, 1'b1, "R5");
        sample(16'd100, "R5");
        load(16'd0, 16'h8000, 1'b0, "R6");
        sample(16'd40000, "R6");
        load(16'hC000, 16'h4000, 1'b1, "R6");      // offset -16384
        sample(16'hF000, "R6");
        load(16'd0, 16'h4000, 1'b0, "R7");
        sample(16'h0000, "R7");
        sample(16'hFFFF, "R7");
        load(16'd0, 16'h4000, 1'b1, "R8");
        sample(16'h0000, "R8");
        sample(16'hFFFF, "R8");
        sample(16'h8000, "R8");
        idle(2);

        // R9: write in the same cycle as an accepted sample, samples back to back
        load(16'd0, 16'h4000, 1'b0, "R9");
        sample(16'd1000, "R9");
        drive(1'b1, 16'd1000, 1'b1, 16'd10, 16'h8000, 1'b1, "R9");
        sample(16'd1000, "R9");
        drive(1'b1, 16'd500, 1'b1, 16'd0, 16'h4000, 1'b0, "R9");
        sample(16'd500, "R9");
        // R10: factors persist across gaps with no further writes
        load(16'd50, 16'h3000, 1'b1, "R10");
        idle(5);
        for (int i = 0; i < 6; i++) sample(16'(i * 9000 + 77), "R10");
        idle(2);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            bit v = ($urandom % 4) != 0;
            bit w = ($urandom % 12) == 0;
            logic [15:0] o = ($urandom % 2) ? 16'($urandom % 512) - 16'd256 : 16'($urandom);
            logic [15:0] g = 16'($urandom);
            logic [15:0] d = ($urandom % 8 == 0) ? (($urandom % 2) ? 16'hFFFF : 16'h0000)
                                                 : 16'($urandom);
            drive(v, d, w, o, g, 1'($urandom), "R10");
        end
        idle(4);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog expired got hang exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule